// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Message Unit

This block is a mailbox between two processors, called side A and side B. Each side has its own 32-bit register bus. On each side there are four transmit slots, four receive slots, one status word and one control word. A word written into transmit slot n on one side is held for the peer and is read from receive slot n on the other side. A full/empty handshake exists for each slot and each direction, so the sender can tell when the peer has taken a word. Four doorbell lines in each direction let one side raise an event on the other without sending data.

Each side has one registered interrupt output. It is the OR of every status flag on that side that has its enable bit set. Both sides run on one clock. Read data comes back one cycle after the read strobe.

Address map, per side (byte offsets, the two low address bits are ignored):

| Offset | Access | Meaning |
|---|---|---|
| 0x00 + 4n | write only | transmit slot n (0 to 3) |
| 0x10 + 4n | read only | receive slot n (0 to 3) |
| 0x20 | read, write 1 to clear | status word |
| 0x24 | read and write | control word |

Top module: `msg_unit_dual`

## Requirements
- R1: After reset, on both sides, every transmit-empty flag is 1, every receive-full flag and doorbell-pending flag is 0, the control word is 0, all receive slots read 0 and both interrupts are 0.
- R2: A write to transmit slot n (offset 0x00+4n) on one side stores the word in receive slot n (offset 0x10+4n) of the other side. It clears the writer's transmit-empty flag n and sets the peer's receive-full flag n.
- R3: A read of receive slot n returns the held word. It clears the reader's receive-full flag n and sets the sender's transmit-empty flag n again.
- R4: A write to transmit slot n while its empty flag is 0 replaces the held word and leaves all flags unchanged.
- R5: In the status word at offset 0x20, transmit-empty n is at bit 20+(3-n), receive-full n is at bit 24+(3-n) and doorbell-pending n is at bit 28+(3-n). All other bits read 0.
- R6: In the control word at offset 0x24, the doorbell request n is at bit 16+(3-n), the transmit interrupt enable n is at bit 20+(3-n), the receive interrupt enable n is at bit 24+(3-n) and the doorbell interrupt enable n is at bit 28+(3-n). The enables read back as they were written.
- R7: Writing 1 to doorbell request bit n on one side sets doorbell-pending n on the other side. The request bit reads 1 until that pending flag is cleared. Writing 0 to a request bit has no effect.
- R8: Writing 1 to doorbell-pending bit n in the status word clears that flag, and the peer's request bit n clears with it. Writing 0 to the bit has no effect.
- R9: A side's interrupt is 1 when any transmit-empty, receive-full or doorbell-pending flag is 1 and its enable bit is also 1. The interrupt follows a change of flag or enable with a delay of one clock cycle.
- R10: Reads of unmapped offsets return 0. Writes to receive slots or unmapped offsets change no state.
- R11: If a side writes transmit slot n in the same cycle that the peer reads receive slot n, the read returns the old word. The slot then stays full and holds the new word.
- R12: Read data appears on the read-data port in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous reset, active high |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | 8 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, registered |
| a_irq | output | 1 | Side A interrupt, registered |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | 8 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, registered |
| b_irq | output | 1 | Side B interrupt, registered |

## Verification
A bad slot occupancy bit is seen in the status word of both sides on the first read after the faulty cycle. The receiver's full flag and the sender's empty flag must always be opposite, so a bench that compares the two words finds the fault. A data register that is latched wrong is seen only when the peer reads the slot, which can be many cycles later, so each transfer is read back and compared. A wrong enable or doorbell bit is seen on the interrupt pin one cycle after the flag changes. Because of this, the interrupt is sampled exactly one cycle after each change and not only at the end of a test.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned NUM_SIDES = 2;

  // byte offsets of the register groups
  localparam logic [ADDR_W-1:0] OFS_TX   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_RX   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h24;

  // lowest bit of each flag/control nibble
  localparam int unsigned POS_REQ = 16;
  localparam int unsigned POS_TE  = 20;
  localparam int unsigned POS_RF  = 24;
  localparam int unsigned POS_GP  = 28;

  // slot n lives at nibble bit (3-n): mirror a per-slot vector
  function automatic logic [NUM_SLOTS-1:0] rev_slots(input logic [NUM_SLOTS-1:0] v);
    logic [NUM_SLOTS-1:0] r;
    for (int i = 0; i < NUM_SLOTS; i++) r[NUM_SLOTS-1-i] = v[i];
    return r;
  endfunction
endpackage

// File: rtl/mu_slot_chan.sv
module mu_slot_chan #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic          full,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr) data <= wdata;
      if (wr)      full <= 1'b1;
      else if (rd) full <= 1'b0;
    end
  end

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
    wr |=> full); // R2
  AST_WRITE_LATCH: assert property (@(posedge clk) disable iff (rst)
    wr |=> (data == $past(wdata))); // R4
  AST_READ_DRAINS: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr) |=> !full); // R3
  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(data)); // R11
endmodule

// File: rtl/mu_doorbell.sv
module mu_doorbell #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | set;
  end

  AST_DB_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((pend & $past(set)) == $past(set))); // R7
  AST_DB_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~set)) |=> ((pend & $past(clr & ~set)) == '0)); // R8
endmodule

// File: rtl/mu_side_port.sv
module mu_side_port
  import mu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NS = NUM_SLOTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic                 irq,
  input  logic [NS-1:0]        tx_empty,
  input  logic [NS-1:0]        rx_full,
  input  logic [NS-1:0][DW-1:0] rx_data,
  input  logic [NS-1:0]        gp_pend,
  input  logic [NS-1:0]        gp_req,
  output logic [NS-1:0]        tx_wr,
  output logic [NS-1:0]        rx_rd,
  output logic [NS-1:0]        pend_clr,
  output logic [NS-1:0]        req_set
);
  localparam int unsigned SLOT_W = $clog2(NS);
  localparam int unsigned GRP_LSB = SLOT_W + 2;

  logic [AW-1:0]     wa;
  logic [SLOT_W-1:0] slot;
  logic              hit_tx, hit_rx, hit_stat, hit_ctrl, hit_none;
  logic [NS-1:0]     tie, rie, gie;
  logic [DW-1:0]     stat_word, ctrl_word, rd_mux;

  assign wa       = {addr[AW-1:2], 2'b00};
  assign slot     = addr[GRP_LSB-1:2];
  assign hit_tx   = (wa[AW-1:GRP_LSB] == OFS_TX[AW-1:GRP_LSB]);
  assign hit_rx   = (wa[AW-1:GRP_LSB] == OFS_RX[AW-1:GRP_LSB]);
  assign hit_stat = (wa == OFS_STAT);
  assign hit_ctrl = (wa == OFS_CTRL);
  assign hit_none = !(hit_tx || hit_rx || hit_stat || hit_ctrl);

  generate
    for (genvar n = 0; n < NS; n++) begin : g_strobe
      assign tx_wr[n] = wr && hit_tx && (slot == SLOT_W'(n));
      assign rx_rd[n] = rd && hit_rx && (slot == SLOT_W'(n));
    end
  endgenerate

  assign pend_clr = (wr && hit_stat) ? rev_slots(wdata[POS_GP +: NS]) : '0;
  assign req_set  = (wr && hit_ctrl) ? rev_slots(wdata[POS_REQ +: NS]) : '0;

  always_comb begin
    stat_word = '0;
    stat_word[POS_TE +: NS] = rev_slots(tx_empty);
    stat_word[POS_RF +: NS] = rev_slots(rx_full);
    stat_word[POS_GP +: NS] = rev_slots(gp_pend);
    ctrl_word = '0;
    ctrl_word[POS_REQ +: NS] = rev_slots(gp_req);
    ctrl_word[POS_TE  +: NS] = rev_slots(tie);
    ctrl_word[POS_RF  +: NS] = rev_slots(rie);
    ctrl_word[POS_GP  +: NS] = rev_slots(gie);
    rd_mux = '0;
    if (hit_rx)        rd_mux = rx_data[slot];
    else if (hit_stat) rd_mux = stat_word;
    else if (hit_ctrl) rd_mux = ctrl_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tie   <= '0;
      rie   <= '0;
      gie   <= '0;
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr && hit_ctrl) begin
        tie <= rev_slots(wdata[POS_TE +: NS]);
        rie <= rev_slots(wdata[POS_RF +: NS]);
        gie <= rev_slots(wdata[POS_GP +: NS]);
      end
      if (rd) rdata <= rd_mux;
      irq <= |((tx_empty & tie) | (rx_full & rie) | (gp_pend & gie));
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ((tie == '0) && (rie == '0) && (gie == '0)) |=> !irq); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && hit_none) |=> (rdata == '0)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata)); // R12
  AST_ONE_SLOT_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_wr)); // R2
endmodule

// File: rtl/msg_unit_dual.sv
module msg_unit_dual
  import mu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NS = NUM_SLOTS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam int unsigned SIDES = NUM_SIDES;

  logic [SIDES-1:0]                 s_wr, s_rd, s_irq;
  logic [SIDES-1:0][AW-1:0]         s_addr;
  logic [SIDES-1:0][DW-1:0]         s_wdata, s_rdata;
  logic [SIDES-1:0][NS-1:0]         tx_wr, rx_rd, pend_clr, req_set;
  // full[d][n]: slot n carrying data from side d to side 1-d
  logic [SIDES-1:0][NS-1:0]         full;
  logic [SIDES-1:0][NS-1:0][DW-1:0] slot_data;
  // bell[d][n]: doorbell n raised by side d toward side 1-d
  logic [SIDES-1:0][NS-1:0]         bell;

  assign s_wr    = {b_wr, a_wr};
  assign s_rd    = {b_rd, a_rd};
  assign s_addr  = {b_addr, a_addr};
  assign s_wdata = {b_wdata, a_wdata};
  assign a_rdata = s_rdata[0];
  assign b_rdata = s_rdata[1];
  assign a_irq   = s_irq[0];
  assign b_irq   = s_irq[1];

  generate
    for (genvar d = 0; d < SIDES; d++) begin : g_dir
      for (genvar n = 0; n < NS; n++) begin : g_slot
        mu_slot_chan #(.DW(DW)) u_slot (
          .clk   (clk),
          .rst   (rst),
          .wr    (tx_wr[d][n]),
          .rd    (rx_rd[SIDES-1-d][n]),
          .wdata (s_wdata[d]),
          .full  (full[d][n]),
          .data  (slot_data[d][n])
        );
      end

      mu_doorbell #(.N(NS)) u_bell (
        .clk  (clk),
        .rst  (rst),
        .set  (req_set[d]),
        .clr  (pend_clr[SIDES-1-d]),
        .pend (bell[d])
      );

      mu_side_port #(.DW(DW), .AW(AW), .NS(NS)) u_port (
        .clk      (clk),
        .rst      (rst),
        .wr       (s_wr[d]),
        .rd       (s_rd[d]),
        .addr     (s_addr[d]),
        .wdata    (s_wdata[d]),
        .rdata    (s_rdata[d]),
        .irq      (s_irq[d]),
        .tx_empty (~full[d]),
        .rx_full  (full[SIDES-1-d]),
        .rx_data  (slot_data[SIDES-1-d]),
        .gp_pend  (bell[SIDES-1-d]),
        .gp_req   (bell[d]),
        .tx_wr    (tx_wr[d]),
        .rx_rd    (rx_rd[d]),
        .pend_clr (pend_clr[d]),
        .req_set  (req_set[d])
      );
    end
  endgenerate

  AST_IRQ_A_QUIET_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !a_irq); // R1
  AST_IRQ_B_QUIET_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !b_irq); // R1
endmodule

// File: tb/test_msg_unit_dual.sv
module test_msg_unit_dual;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [7:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk; // 250 MHz

  msg_unit_dual i_msg_unit_dual (
    .clk(clk), .rst(rst),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  localparam logic [31:0] TE_ALL = 32'h00F0_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input bit side, input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (side) begin b_wr = 1; b_addr = ad; b_wdata = d; end
    else      begin a_wr = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic bus_rd(input bit side, input logic [7:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (side) begin b_rd = 1; b_addr = ad; end
    else      begin a_rd = 1; a_addr = ad; end
    @(negedge clk);
    a_rd = 0; b_rd = 0;
    d = side ? b_rdata : a_rdata;
  endtask

  task automatic rd_check(input bit side, input logic [7:0] ad, input logic [31:0] exp, input string req);
    logic [31:0] v;
    bus_rd(side, ad, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    check("R1 irq A", {31'b0, a_irq}, 32'h0);
    check("R1 irq B", {31'b0, b_irq}, 32'h0);
    rd_check(0, 8'h20, TE_ALL, "R1 status A");
    rd_check(1, 8'h20, TE_ALL, "R1 status B");
    rd_check(0, 8'h24, 32'h0, "R1 ctrl A");
    rd_check(1, 8'h14, 32'h0, "R1 rx B slot1");
  endtask

  task automatic t_transfer;
    bus_wr(0, 8'h04, 32'hDEAD_BEEF);
    rd_check(0, 8'h20, 32'h00B0_0000, "R2 R5 sender empty1 cleared");
    rd_check(1, 8'h20, 32'h04F0_0000, "R2 R5 receiver full1 set");
    rd_check(1, 8'h14, 32'hDEAD_BEEF, "R3 R12 receive word");
    rd_check(1, 8'h20, TE_ALL, "R3 receiver full1 cleared");
    rd_check(0, 8'h20, TE_ALL, "R3 sender empty1 restored");
  endtask

  task automatic t_overwrite;
    bus_wr(1, 8'h00, 32'h0000_0001);
    bus_wr(1, 8'h00, 32'h0000_0002);
    rd_check(1, 8'h20, 32'h0070_0000, "R4 sender flags unchanged");
    rd_check(0, 8'h20, 32'h08F0_0000, "R4 receiver flags unchanged");
    rd_check(0, 8'h10, 32'h0000_0002, "R4 newest word kept");
  endtask

  task automatic t_doorbell;
    bus_wr(0, 8'h24, 32'h0002_0000); // request slot 2
    rd_check(1, 8'h20, 32'h20F0_0000, "R7 pending2 at peer");
    rd_check(0, 8'h24, 32'h0002_0000, "R6 R7 request bit held");
    bus_wr(0, 8'h24, 32'h0000_0000);
    rd_check(0, 8'h24, 32'h0002_0000, "R7 zero write keeps request");
    bus_wr(1, 8'h20, 32'h0000_0000);
    rd_check(1, 8'h20, 32'h20F0_0000, "R8 zero write keeps pending");
    bus_wr(1, 8'h20, 32'h2000_0000);
    rd_check(1, 8'h20, TE_ALL, "R8 pending cleared");
    rd_check(0, 8'h24, 32'h0, "R8 request self clears");
  endtask

  task automatic t_irq;
    logic [31:0] v;
    bus_wr(1, 8'h24, 32'h0800_0000); // rx enable slot0 on B
    rd_check(1, 8'h24, 32'h0800_0000, "R6 enable readback");
    check("R9 irq B idle", {31'b0, b_irq}, 32'h0);
    bus_wr(0, 8'h00, 32'h1234_5678);
    check("R9 irq B not yet", {31'b0, b_irq}, 32'h0);
    @(negedge clk);
    check("R9 irq B rx full", {31'b0, b_irq}, 32'h1);
    bus_rd(1, 8'h10, v);
    check("R3 word slot0", v, 32'h1234_5678);
    @(negedge clk);
    check("R9 irq B drained", {31'b0, b_irq}, 32'h0);
    bus_wr(0, 8'h24, 32'h0010_0000); // tx enable slot3 on A
    @(negedge clk);
    check("R9 irq A tx empty", {31'b0, a_irq}, 32'h1);
    bus_wr(0, 8'h24, 32'h0);
    @(negedge clk);
    check("R9 irq A masked", {31'b0, a_irq}, 32'h0);
    bus_wr(1, 8'h24, 32'h4000_0000); // bell enable slot1 on B
    bus_wr(0, 8'h24, 32'h0004_0000); // A rings slot1
    @(negedge clk);
    check("R9 irq B doorbell", {31'b0, b_irq}, 32'h1);
    bus_wr(1, 8'h20, 32'h4000_0000);
    @(negedge clk);
    check("R9 R8 irq B after clear", {31'b0, b_irq}, 32'h0);
    bus_wr(1, 8'h24, 32'h0);
  endtask

  task automatic t_unmapped;
    bus_wr(0, 8'h30, 32'hFFFF_FFFF);
    rd_check(0, 8'h30, 32'h0, "R10 unmapped read");
    rd_check(0, 8'h3C, 32'h0, "R10 unmapped read high");
    bus_wr(0, 8'h10, 32'hAAAA_5555);
    rd_check(0, 8'h20, TE_ALL, "R10 rx write no flag A");
    rd_check(1, 8'h20, TE_ALL, "R10 rx write no flag B");
    rd_check(0, 8'h24, 32'h0, "R10 ctrl untouched");
  endtask

  task automatic t_collide;
    logic [31:0] v;
    bus_wr(0, 8'h08, 32'h0000_00AA);
    @(negedge clk);
    a_wr = 1; a_addr = 8'h08; a_wdata = 32'h0000_00BB;
    b_rd = 1; b_addr = 8'h18;
    @(negedge clk);
    a_wr = 0; b_rd = 0;
    v = b_rdata;
    check("R11 read returns old word", v, 32'h0000_00AA);
    rd_check(1, 8'h20, 32'h02F0_0000, "R11 slot stays full");
    rd_check(1, 8'h18, 32'h0000_00BB, "R11 new word held");
    rd_check(0, 8'h20, TE_ALL, "R11 sender empty after drain");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_transfer();
    t_overwrite();
    t_doorbell();
    t_irq();
    t_unmapped();
    t_collide();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule